// File: doc/BRIEF.md
# Outstanding Read-Miss Tracker

This block sits beside a data cache and keeps the cache usable while read misses wait for memory. When a lookup misses, the requester presents the miss address and a request tag. A miss to a cache line that nothing is waiting on takes a fill entry. That entry later sends exactly one read request on the memory side. A miss to a line that already owns a fill entry does not go to memory again. It is parked in a small pend queue and linked to that fill entry. Lookups that hit never pass through this block, so they keep flowing whether or not misses are outstanding.

When memory answers a fill entry, the block replays the tags waiting on that line, one per cycle. The tag of the miss that opened the entry comes first, then the parked tags in the order they arrived. After that the entry becomes free. A drain input closes the miss port until every fill entry and every pend entry is empty, and a one-cycle completion pulse then reports that the block is quiet.

Top module: `miss_fill_pend`

## Requirements
- R1: The tracker holds four fill entries. No two occupied entries ever hold the same line address, where the line address is `miss_addr[31:5]` (32-byte lines).
- R2: After reset every entry is free: `miss_ready` is 1, and `rd_req_valid`, `rel_valid` and `drain_done` are 0. A miss whose line matches no occupied fill entry, while a free entry exists, is accepted and takes the lowest-numbered free entry. That index later appears on `rd_req_idx`.
- R3: A miss whose line matches no occupied fill entry while all four entries are occupied sees `miss_ready` = 0 in that cycle. `miss_ready` never depends on `miss_valid`.
- R4: A miss whose line matches an occupied fill entry is accepted into the pend queue, which has four entries shared by all fill entries. It causes no read request.
- R5: A miss that matches an occupied fill entry while the pend queue holds four entries sees `miss_ready` = 0.
- R6: `rd_req_valid` is 1 whenever some fill entry has not yet issued its read. Requests leave in the order the entries were allocated. Each request is held until `rd_req_ready` and carries the line and the entry index, and each entry is requested once.
- R7: After `rd_rsp_valid` with index k, `rel_valid` pulses once per tag waiting on entry k, one tag per cycle. The opening miss comes first, then the parked misses in arrival order, with `rel_line` equal to entry k's line. The releases of one entry are not interleaved with those of another.
- R8: Address bits [4:0] play no part in matching. A miss that arrives while its line is still being released joins that release. Once an entry's last tag is out, the entry is freed and may take any new line.
- R9: A `drain_req` pulse forces `miss_ready` to 0 from that cycle on. When both buffers are empty, `drain_done` is 1 for exactly one cycle and the miss port reopens. A `drain_req` raised during a drain has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| miss_valid | input | 1 | A read miss is presented |
| miss_addr | input | 32 | Byte address of the miss |
| miss_tag | input | 4 | Requester tag returned on release |
| miss_ready | output | 1 | Miss accepted this cycle when 1 (stall when 0) |
| rd_req_valid | output | 1 | Memory read request pending |
| rd_req_ready | input | 1 | Memory side takes the request |
| rd_req_line | output | 27 | Line address of the request |
| rd_req_idx | output | 2 | Fill entry issuing the request |
| rd_rsp_valid | input | 1 | Line data for a fill entry has returned |
| rd_rsp_idx | input | 2 | Fill entry the response belongs to |
| rel_valid | output | 1 | A waiting miss is released this cycle |
| rel_tag | output | 4 | Tag of the released miss |
| rel_line | output | 27 | Line address of the released miss |
| drain_req | input | 1 | Pulse to start a drain |
| drain_done | output | 1 | One-cycle pulse when the drain has emptied both buffers |

## Verification
A corrupted fill entry state shows up on `miss_ready` at the very next miss to that line. It also shows up on `rd_req_valid`/`rd_req_idx` in the cycle after the allocation, as an extra, missing or out-of-order request. A damaged pend link or pend order shows as a wrong `rel_tag` or `rel_line` in the cycle the tag would be released, which is at most a few cycles after the response. An entry that is never freed keeps `drain_done` from firing and stalls the next distinct miss once the other entries fill, so a leaked entry is visible as a missing completion pulse at the end of any drain.

// File: rtl/mfp_pkg.sv
package mfp_pkg;

  // Life of one fill entry: waits to send its read, waits for data,
  // replays its tags, then returns to free.
  typedef enum logic [1:0] {
    FE_FREE  = 2'd0,
    FE_ISSUE = 2'd1,
    FE_WAIT  = 2'd2,
    FE_REL   = 2'd3
  } fe_state_t;

endpackage

// File: rtl/mfp_fill_table.sv
module mfp_fill_table
  import mfp_pkg::*;
#(
  parameter int LA_W  = 27,
  parameter int TAG_W = 4,
  parameter int FB_N  = 4,
  localparam int FI_W = (FB_N > 1) ? $clog2(FB_N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LA_W-1:0]  lk_line,
  output logic             lk_hit,
  output logic [FI_W-1:0]  lk_idx,
  output logic             has_free,
  output logic [FI_W-1:0]  free_idx,
  output logic             all_free,
  input  logic             alloc_en,
  input  logic [TAG_W-1:0] alloc_tag,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [LA_W-1:0]  req_line,
  output logic [FI_W-1:0]  req_idx,
  input  logic             rsp_valid,
  input  logic [FI_W-1:0]  rsp_idx,
  output logic             rel_any,
  output logic [FI_W-1:0]  rel_pick,
  input  logic [FI_W-1:0]  act_idx,
  output logic [LA_W-1:0]  act_line,
  output logic [TAG_W-1:0] act_tag,
  output logic             act_pdone,
  input  logic             prim_emit,
  input  logic             free_en
);

  fe_state_t        st_q    [FB_N];
  fe_state_t        st_d    [FB_N];
  logic             pdone_q [FB_N];
  logic             pdone_d [FB_N];
  logic [LA_W-1:0]  line_q  [FB_N];
  logic [TAG_W-1:0] tag_q   [FB_N];

  // allocation-order queue of entry indices waiting to issue
  logic [FI_W-1:0]  iq_q [FB_N];
  logic [FI_W-1:0]  iq_rd_q, iq_rd_d, iq_wr_q, iq_wr_d;
  logic [FI_W:0]    iq_cnt_q, iq_cnt_d;
  logic             iq_pop;

  function automatic logic [FI_W-1:0] ptr_inc(input logic [FI_W-1:0] p);
    return (p == FI_W'(FB_N - 1)) ? '0 : p + 1'b1;
  endfunction

  // line match, lowest free slot, lowest entry ready to replay
  always_comb begin
    lk_hit   = 1'b0;
    lk_idx   = '0;
    has_free = 1'b0;
    free_idx = '0;
    all_free = 1'b1;
    rel_any  = 1'b0;
    rel_pick = '0;
    for (int i = FB_N - 1; i >= 0; i--) begin
      if (st_q[i] != FE_FREE && line_q[i] == lk_line) begin
        lk_hit = 1'b1;
        lk_idx = FI_W'(i);
      end
      if (st_q[i] == FE_FREE) begin
        has_free = 1'b1;
        free_idx = FI_W'(i);
      end else begin
        all_free = 1'b0;
      end
      if (st_q[i] == FE_REL) begin
        rel_any  = 1'b1;
        rel_pick = FI_W'(i);
      end
    end
  end

  assign req_valid = (iq_cnt_q != '0);
  assign req_idx   = iq_q[iq_rd_q];
  assign req_line  = line_q[req_idx];
  assign iq_pop    = req_valid && req_ready;
  assign act_line  = line_q[act_idx];
  assign act_tag   = tag_q[act_idx];
  assign act_pdone = pdone_q[act_idx];

  always_comb begin
    for (int i = 0; i < FB_N; i++) begin
      st_d[i]    = st_q[i];
      pdone_d[i] = pdone_q[i];
      if (alloc_en && free_idx == FI_W'(i)) begin
        st_d[i]    = FE_ISSUE;
        pdone_d[i] = 1'b0;
      end else if (iq_pop && req_idx == FI_W'(i)) begin
        st_d[i] = FE_WAIT;
      end else if (rsp_valid && rsp_idx == FI_W'(i) && st_q[i] == FE_WAIT) begin
        st_d[i] = FE_REL;
      end else if (free_en && act_idx == FI_W'(i)) begin
        st_d[i] = FE_FREE;
      end
      if (prim_emit && act_idx == FI_W'(i)) begin
        pdone_d[i] = 1'b1;
      end
    end
    iq_rd_d  = iq_pop   ? ptr_inc(iq_rd_q) : iq_rd_q;
    iq_wr_d  = alloc_en ? ptr_inc(iq_wr_q) : iq_wr_q;
    iq_cnt_d = iq_cnt_q + (FI_W+1)'(alloc_en) - (FI_W+1)'(iq_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < FB_N; i++) begin
        st_q[i]    <= FE_FREE;
        pdone_q[i] <= 1'b0;
      end
      iq_rd_q  <= '0;
      iq_wr_q  <= '0;
      iq_cnt_q <= '0;
    end else begin
      st_q     <= st_d;
      pdone_q  <= pdone_d;
      iq_rd_q  <= iq_rd_d;
      iq_wr_q  <= iq_wr_d;
      iq_cnt_q <= iq_cnt_d;
    end
  end

  // payload registers: written only on allocation, no reset needed
  always_ff @(posedge clk) begin
    if (alloc_en) begin
      line_q[free_idx] <= lk_line;
      tag_q[free_idx]  <= alloc_tag;
      iq_q[iq_wr_q]    <= free_idx;
    end
  end

  generate
    for (genvar i = 0; i < FB_N; i++) begin : g_ent_chk
      for (genvar j = i + 1; j < FB_N; j++) begin : g_pair
        AST_FB_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
          !(st_q[i] != FE_FREE && st_q[j] != FE_FREE && line_q[i] == line_q[j])); // R1
      end
      AST_NO_SKIP_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q[i] == FE_ISSUE |=> st_q[i] != FE_REL); // R7
    end
  endgenerate

  AST_ALLOC_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> st_q[free_idx] == FE_FREE); // R2
  AST_ISSUE_FROM_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> st_q[req_idx] == FE_ISSUE); // R6
  AST_RSP_TO_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> st_q[rsp_idx] == FE_WAIT); // R7

endmodule

// File: rtl/mfp_pend_queue.sv
module mfp_pend_queue #(
  parameter int TAG_W  = 4,
  parameter int PB_N   = 4,
  parameter int FB_N   = 4,
  localparam int FI_W  = (FB_N > 1) ? $clog2(FB_N) : 1,
  localparam int PI_W  = (PB_N > 1) ? $clog2(PB_N) : 1,
  localparam int CNT_W = $clog2(PB_N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [FI_W-1:0]  push_link,
  input  logic [TAG_W-1:0] push_tag,
  input  logic [FI_W-1:0]  look_link,
  input  logic             pop,
  output logic             hit,
  output logic [TAG_W-1:0] hit_tag,
  output logic             full,
  output logic             empty
);

  // entries kept compacted in arrival order; slot 0 is the oldest
  logic [FI_W-1:0]  link_q [PB_N];
  logic [FI_W-1:0]  link_d [PB_N];
  logic [TAG_W-1:0] tag_q  [PB_N];
  logic [TAG_W-1:0] tag_d  [PB_N];
  logic [CNT_W-1:0] cnt_q, cnt_d, ins_pos;
  logic [PI_W-1:0]  hit_pos;

  always_comb begin
    hit     = 1'b0;
    hit_pos = '0;
    for (int i = PB_N - 1; i >= 0; i--) begin
      if (CNT_W'(i) < cnt_q && link_q[i] == look_link) begin
        hit     = 1'b1;
        hit_pos = PI_W'(i);
      end
    end
  end

  assign hit_tag = tag_q[hit_pos];
  assign full    = (cnt_q == CNT_W'(PB_N));
  assign empty   = (cnt_q == '0);

  always_comb begin
    ins_pos = cnt_q - CNT_W'(pop);
    cnt_d   = cnt_q + CNT_W'(push) - CNT_W'(pop);
    for (int i = 0; i < PB_N; i++) begin
      int src;
      src = (pop && PI_W'(i) >= hit_pos) ? i + 1 : i;
      if (src > PB_N - 1) src = PB_N - 1;
      link_d[i] = link_q[src];
      tag_d[i]  = tag_q[src];
      if (push && ins_pos == CNT_W'(i)) begin
        link_d[i] = push_link;
        tag_d[i]  = push_tag;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push || pop) begin
      link_q <= link_d;
      tag_q  <= tag_d;
    end
  end

  AST_PQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R5
  AST_PQ_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R7

endmodule

// File: rtl/miss_fill_pend.sv
module miss_fill_pend #(
  parameter int ADDR_W     = 32,
  parameter int TAG_W      = 4,
  parameter int LINE_BYTES = 32,
  parameter int FB_N       = 4,
  parameter int PB_N       = 4,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LA_W      = ADDR_W - OFF_W,
  localparam int FI_W      = (FB_N > 1) ? $clog2(FB_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [TAG_W-1:0]  miss_tag,
  output logic              miss_ready,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [LA_W-1:0]   rd_req_line,
  output logic [FI_W-1:0]   rd_req_idx,
  input  logic              rd_rsp_valid,
  input  logic [FI_W-1:0]   rd_rsp_idx,
  output logic              rel_valid,
  output logic [TAG_W-1:0]  rel_tag,
  output logic [LA_W-1:0]   rel_line,
  input  logic              drain_req,
  output logic              drain_done
);

  logic [1:0]       rs_q;
  logic             rst_n_s;
  logic [LA_W-1:0]  miss_line;
  logic             unused_offset;
  logic             lk_hit, has_free, all_free, rel_any, act_pdone;
  logic [FI_W-1:0]  lk_idx, free_idx, rel_pick, act_idx;
  logic [LA_W-1:0]  act_line;
  logic [TAG_W-1:0] act_tag, pq_tag;
  logic             pq_hit, pq_full, pq_empty;
  logic             accept, alloc_en, sec_push;
  logic             rel_go, prim_emit, pq_pop, free_en;
  logic             busy_q, busy_d, drain_q, drain_d;
  logic [FI_W-1:0]  cur_q, cur_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  assign miss_line     = miss_addr[ADDR_W-1:OFF_W];
  assign unused_offset = ^miss_addr[OFF_W-1:0];

  mfp_fill_table #(
    .LA_W (LA_W),
    .TAG_W(TAG_W),
    .FB_N (FB_N)
  ) u_fill (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .lk_line  (miss_line),
    .lk_hit   (lk_hit),
    .lk_idx   (lk_idx),
    .has_free (has_free),
    .free_idx (free_idx),
    .all_free (all_free),
    .alloc_en (alloc_en),
    .alloc_tag(miss_tag),
    .req_valid(rd_req_valid),
    .req_ready(rd_req_ready),
    .req_line (rd_req_line),
    .req_idx  (rd_req_idx),
    .rsp_valid(rd_rsp_valid),
    .rsp_idx  (rd_rsp_idx),
    .rel_any  (rel_any),
    .rel_pick (rel_pick),
    .act_idx  (act_idx),
    .act_line (act_line),
    .act_tag  (act_tag),
    .act_pdone(act_pdone),
    .prim_emit(prim_emit),
    .free_en  (free_en)
  );

  mfp_pend_queue #(
    .TAG_W(TAG_W),
    .PB_N (PB_N),
    .FB_N (FB_N)
  ) u_pend (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .push     (sec_push),
    .push_link(lk_idx),
    .push_tag (miss_tag),
    .look_link(act_idx),
    .pop      (pq_pop),
    .hit      (pq_hit),
    .hit_tag  (pq_tag),
    .full     (pq_full),
    .empty    (pq_empty)
  );

  // miss port: secondary misses need pend room, primaries need a free slot
  assign miss_ready = !drain_q && !drain_req && (lk_hit ? !pq_full : has_free);
  assign accept     = miss_valid && miss_ready;
  assign alloc_en   = accept && !lk_hit;
  assign sec_push   = accept && lk_hit;

  // release engine: sticks to one entry until that entry is freed
  always_comb begin
    act_idx   = busy_q ? cur_q : rel_pick;
    rel_go    = busy_q || rel_any;
    prim_emit = rel_go && !act_pdone;
    pq_pop    = rel_go && act_pdone && pq_hit;
    free_en   = rel_go && act_pdone && !pq_hit && !(sec_push && lk_idx == act_idx);
    busy_d    = rel_go && !free_en;
    cur_d     = act_idx;
  end

  assign rel_valid = prim_emit || pq_pop;
  assign rel_tag   = prim_emit ? act_tag : pq_tag;
  assign rel_line  = act_line;

  assign drain_done = drain_q && all_free && pq_empty;
  assign drain_d    = drain_q ? !drain_done : drain_req;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      busy_q  <= 1'b0;
      cur_q   <= '0;
      drain_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      cur_q   <= cur_d;
      drain_q <= drain_d;
    end
  end

  AST_DRAIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    drain_done |=> !drain_done); // R9
  AST_REL_SAME_LINE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rel_valid && busy_q) |-> rel_line == $past(rel_line)); // R7

endmodule

// File: tb/sim_miss_fill_pend.sv
module sim_miss_fill_pend;

  localparam int LW = 27;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          miss_valid, miss_ready;
  logic [31:0]   miss_addr;
  logic [TW-1:0] miss_tag;
  logic          rd_req_valid, rd_req_ready;
  logic [LW-1:0] rd_req_line;
  logic [1:0]    rd_req_idx;
  logic          rd_rsp_valid;
  logic [1:0]    rd_rsp_idx;
  logic          rel_valid;
  logic [TW-1:0] rel_tag;
  logic [LW-1:0] rel_line;
  logic          drain_req, drain_done;

  always #10 clk = ~clk;

  miss_fill_pend u0 (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_tag(miss_tag), .miss_ready(miss_ready),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_line(rd_req_line), .rd_req_idx(rd_req_idx),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_idx(rd_rsp_idx),
    .rel_valid(rel_valid), .rel_tag(rel_tag), .rel_line(rel_line),
    .drain_req(drain_req), .drain_done(drain_done)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit fin   = 1'b0;

  // reference model of the requirements
  bit            m_occ [4];
  bit            m_rel [4];
  bit            m_last[4];
  bit            m_pd  [4];
  logic [LW-1:0] m_line[4];
  logic [TW-1:0] m_q   [4][8];
  int            m_qn  [4];
  int            iq[$];
  int            outl[$];
  bit            m_drain = 1'b0;
  logic [TW-1:0] tag_ctr = '0;
  logic [LW-1:0] pool[6];

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic int pend_cnt();
    int s = 0;
    for (int e = 0; e < 4; e++)
      if (m_occ[e]) s += m_qn[e] - (m_pd[e] ? 0 : 1);
    return s;
  endfunction

  task automatic step(input bit mv, input logic [LW-1:0] ln, input bit rr,
                      input bit rv, input bit dq);
    logic [31:0] ad;
    int  ri = 0, rpos = 0, hi = -1, fe = -1, pc, re = -1;
    bit  hit = 1'b0, exp_rdy, exp_done, acc, allf;
    string rq;
    ad = {ln, 5'($urandom)};
    @(negedge clk);
    if (rv && outl.size() > 0) begin
      rpos = $urandom % outl.size();
      ri   = outl[rpos];
    end else rv = 1'b0;
    miss_valid   = mv;
    miss_addr    = ad;
    miss_tag     = tag_ctr;
    rd_req_ready = rr;
    rd_rsp_valid = rv;
    rd_rsp_idx   = 2'(ri);
    drain_req    = dq;
    #2;
    // predictions from the state at the start of this cycle
    allf = 1'b1;
    for (int e = 3; e >= 0; e--) begin
      if (m_occ[e] && m_line[e] == ln) begin hit = 1'b1; hi = e; end
      if (!m_occ[e]) fe = e; else allf = 1'b0;
    end
    pc = pend_cnt();
    exp_rdy = !m_drain && !dq && (hit ? (pc < 4) : (fe >= 0));
    rq = (m_drain || dq) ? "R9" : hit ? ((pc >= 4) ? "R5" : "R4 R8") : ((fe >= 0) ? "R2" : "R3");
    chk(miss_ready == exp_rdy, rq, "miss_ready", miss_ready, exp_rdy);
    chk(rd_req_valid == (iq.size() != 0), "R6", "rd_req_valid", rd_req_valid, iq.size() != 0);
    if (rd_req_valid && iq.size() != 0) begin
      chk(rd_req_idx == 2'(iq[0]), "R2 R6", "rd_req_idx", rd_req_idx, iq[0]);
      chk(rd_req_line == m_line[iq[0]], "R1 R6", "rd_req_line", rd_req_line, m_line[iq[0]]);
    end
    if (rel_valid) begin
      for (int e = 0; e < 4; e++)
        if (m_occ[e] && m_rel[e] && m_qn[e] > 0 && m_line[e] == rel_line) re = e;
      chk(re >= 0, "R7", "rel_line of a responded entry", rel_line, 0);
      if (re >= 0) chk(rel_tag == m_q[re][0], "R7", "rel_tag order", rel_tag, m_q[re][0]);
    end
    exp_done = m_drain && allf && (pc == 0);
    chk(drain_done == exp_done, "R9", "drain_done", drain_done, exp_done);
    // state updates for the coming edge
    acc = mv && miss_ready;
    for (int e = 0; e < 4; e++)
      if (m_last[e]) begin
        if (acc && hit && hi == e) m_last[e] = 1'b0;
        else begin m_occ[e] = 1'b0; m_rel[e] = 1'b0; m_last[e] = 1'b0; end
      end
    if (acc && !hit && fe >= 0) begin
      m_occ[fe] = 1'b1; m_rel[fe] = 1'b0; m_pd[fe] = 1'b0; m_last[fe] = 1'b0;
      m_line[fe] = ln; m_q[fe][0] = tag_ctr; m_qn[fe] = 1;
      iq.push_back(fe);
    end else if (acc && hit) begin
      m_q[hi][m_qn[hi]] = tag_ctr;
      m_qn[hi]++;
    end
    if (acc) tag_ctr++;
    if (re >= 0) begin
      for (int k = 0; k < 7; k++) m_q[re][k] = m_q[re][k+1];
      m_qn[re]--;
      m_pd[re] = 1'b1;
      if (m_qn[re] == 0) m_last[re] = 1'b1;
    end
    if (rd_req_valid && rr && iq.size() != 0) outl.push_back(iq.pop_front());
    if (rv) begin
      outl.delete(rpos);
      m_rel[ri] = 1'b1;
    end
    if (m_drain && exp_done) m_drain = 1'b0;
    else if (!m_drain && dq) m_drain = 1'b1;
    @(posedge clk);
  endtask

  initial begin
    void'($urandom(32'd5150));
    for (int e = 0; e < 4; e++) begin
      m_occ[e] = 0; m_rel[e] = 0; m_last[e] = 0; m_pd[e] = 0; m_qn[e] = 0;
    end
    for (int k = 0; k < 6; k++) pool[k] = LW'(32'h0012_3400 + k * 7);
    rst_n = 1'b0;
    miss_valid = 0; miss_addr = '0; miss_tag = '0; rd_req_ready = 0;
    rd_rsp_valid = 0; rd_rsp_idx = '0; drain_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    // R2 reset state
    chk(miss_ready == 1'b1, "R2", "reset miss_ready", miss_ready, 1);
    chk(rd_req_valid == 1'b0, "R2", "reset rd_req_valid", rd_req_valid, 0);
    chk(rel_valid == 1'b0, "R2", "reset rel_valid", rel_valid, 0);
    chk(drain_done == 1'b0, "R2", "reset drain_done", drain_done, 0);
    @(posedge clk);
    // fill all four entries with the bus stalled, then a fifth line stalls (R3)
    for (int k = 0; k < 4; k++) step(1, pool[k], 0, 0, 0);
    step(1, pool[4], 0, 0, 0);
    // four secondaries to one line, the fifth stalls on a full pend queue (R5)
    for (int k = 0; k < 5; k++) step(1, pool[0], 0, 0, 0);
    // drain with everything outstanding; misses refused until done (R9)
    step(1, pool[5], 1, 0, 1);
    for (int k = 0; k < 40; k++) step(1, pool[k % 6], 1, 1, 0);
    // random mix
    for (int k = 0; k < 4000; k++)
      step(($urandom % 10) < 6, pool[$urandom % 6], ($urandom % 2) == 0,
           ($urandom % 3) == 0, ($urandom % 100) == 0);
    // final drain must complete with every tag released (R9)
    step(0, '0, 1, 1, 1);
    for (int k = 0; k < 200 && m_drain; k++) step(0, '0, 1, 1, 0);
    chk(!m_drain, "R9", "final drain completes", m_drain, 0);
    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule